// File: doc/BRIEF.md
# Dual-Bank Asynchronous SRAM Controller

This block connects a synchronous request/acknowledge host port to an external asynchronous static RAM made of two 64K x 16 banks. The two banks share the low fifteen address lines, the 16-bit data bus, the write strobe and the output-enable strobe. Each bank has its own active-low select and its own address line 15. The host presents a 17-bit word address, a write flag and 16-bit write data. The controller uses the top address bit to pick the bank, and it times every strobe in whole clock cycles. The cycle counts come from nanosecond parameters divided by the clock period and rounded up.

The controller is built around one state machine with five states. **IDLE** is the only state that accepts a request. The transition *accept-read* moves to **READ_ACCESS**, which holds select and output enable low for the access time. At its end, the transition *read-done* captures the data bus and returns to IDLE. The transition *accept-write* goes to **WRITE_SETUP**. From IDLE, *accept-write-after-read* goes first to **TURNAROUND**, which keeps every strobe high to leave a bus gap, and then takes *gap-done* to WRITE_SETUP. WRITE_SETUP selects the bank with the write strobe still high. The transition *setup-done* enters **WRITE_PULSE**, where the write strobe is low and the controller drives the data bus. The transition *write-done* returns to IDLE. Each finished access raises the acknowledge for exactly one cycle.

The bus pins are kept separate: an output data vector, a drive-enable and an input data vector. The pad ring combines them into the shared tri-state bus.

Top module: `dbsram_ctrl`

## Requirements
- R1: While reset is held and after it is released, both bank selects, write enable and output enable are high (inactive), the data drive-enable is 0, acknowledge is 0 and the read data is 0.
- R2: Host address bit 16 selects the bank. 0 lowers only `sram_sel0_n` and 1 lowers only `sram_sel1_n`. The other bank's select stays high for the whole access, so at most one select is ever low.
- R3: While a bank is selected, `sram_addr` equals host address bits 14:0. The selected bank's line 15 equals host address bit 15 and the unselected bank's line 15 is 0. These values stay stable for the whole access.
- R4: A read keeps the select and output enable low with write enable high for RD_CYC = ceil(T_ACCESS_NS/CLK_NS) cycles, with a minimum of 1 (2 at defaults). The read data is captured on the last of those edges, and acknowledge is seen RD_CYC+1 cycles after the accepting edge.
- R5: A write spends one setup cycle (select low, write enable high), then WP_CYC cycles with write enable low. WP_CYC is the larger of ceil(T_WPULSE_NS/CLK_NS) and ceil(T_DSETUP_NS/CLK_NS), which is 2 at defaults. Output enable stays high for the whole write. Acknowledge is seen WP_CYC+2 cycles after the accepting edge, plus any turnaround.
- R6: The data drive-enable is 1 exactly while write enable is low. It falls on the same edge on which write enable rises, and it is never 1 while output enable is low.
- R7: A write accepted right after a completed read first spends TURN_CYC = ceil(T_TURN_NS/CLK_NS) cycles (1 at defaults) with all strobes high. A write after a write, and any read, starts without this gap.
- R8: A request is accepted only in IDLE while acknowledge is low. Acknowledge lasts one cycle. Changes to the request inputs after acceptance do not alter the address or data driven to the memory.
- R9: A read returns the full 16-bit word last written to the same 17-bit host address. Addresses that differ only in bit 15 or only in bit 16 hold separate words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Host word address; bit 16 picks the bank |
| req_wdata | input | 16 | Host write data |
| req_ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, valid when acknowledge is high after a read |
| sram_addr | output | 15 | Shared low address lines |
| sram_hi0 | output | 1 | Address line 15 of bank 0 |
| sram_hi1 | output | 1 | Address line 15 of bank 1 |
| sram_sel0_n | output | 1 | Active-low select of bank 0 |
| sram_sel1_n | output | 1 | Active-low select of bank 1 |
| sram_we_n | output | 1 | Shared active-low write strobe |
| sram_oe_n | output | 1 | Shared active-low output enable |
| sram_dq_o | output | 16 | Data driven toward the memory |
| sram_dq_drive | output | 1 | Drive-enable for the data bus |
| sram_dq_i | input | 16 | Data read from the memory bus |

## Verification
A state machine stuck in or skipping a timed state shows up within one access as a wrong count of low cycles on the select, output-enable or write strobe, and as a wrong acknowledge latency. A wrong bank decode or a wrong line-15 mapping makes aliased addresses overwrite each other, so the data read back from the four addresses that share low bits differs from what was written at the first read. A missing turnaround shows on the first write after a read, where the select falls one cycle early. A drive-enable that is out of step with the write strobe corrupts the stored word, or shows up as contention in that same cycle.

// File: rtl/dbsram_pkg.sv
`timescale 1ns/1ps
package dbsram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACC,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_TURN
    } ctrl_state_t;

    // Whole clock cycles covering a minimum time, never fewer than one.
    function automatic int ns_to_cycles(input int t_ns, input int clk_ns);
        int c;
        c = (t_ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/dbsram_timer.sv
`timescale 1ns/1ps
module dbsram_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/dbsram_bank_dec.sv
`timescale 1ns/1ps
module dbsram_bank_dec #(
    parameter int SEL_W = 1,
    localparam int NBANK = 1 << SEL_W
) (
    input  logic [SEL_W-1:0] bank_sel,
    input  logic             hi_bit,
    input  logic             active,
    output logic [NBANK-1:0] sel_n,
    output logic [NBANK-1:0] hi_line
);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic hit;
        assign hit        = (bank_sel == SEL_W'(b));
        assign sel_n[b]   = ~(active & hit);
        assign hi_line[b] = hit & hi_bit;
    end

endmodule

// File: rtl/dbsram_ctrl.sv
`timescale 1ns/1ps
module dbsram_ctrl
    import dbsram_pkg::*;
#(
    parameter int CLK_NS      = 5,
    parameter int T_ACCESS_NS = 10,
    parameter int T_WPULSE_NS = 8,
    parameter int T_DSETUP_NS = 6,
    parameter int T_TURN_NS   = 5,
    parameter int ADDR_W      = 17,
    parameter int DATA_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ack,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-3:0] sram_addr,
    output logic              sram_hi0,
    output logic              sram_hi1,
    output logic              sram_sel0_n,
    output logic              sram_sel1_n,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic [DATA_W-1:0] sram_dq_o,
    output logic              sram_dq_drive,
    input  logic [DATA_W-1:0] sram_dq_i
);

    localparam int RD_CYC   = ns_to_cycles(T_ACCESS_NS, CLK_NS);
    localparam int WP_RAW   = ns_to_cycles(T_WPULSE_NS, CLK_NS);
    localparam int DS_RAW   = ns_to_cycles(T_DSETUP_NS, CLK_NS);
    localparam int WP_CYC   = (WP_RAW > DS_RAW) ? WP_RAW : DS_RAW;
    localparam int TURN_CYC = ns_to_cycles(T_TURN_NS, CLK_NS);
    localparam int MAX_A    = (RD_CYC > WP_CYC) ? RD_CYC : WP_CYC;
    localparam int MAX_CYC  = (MAX_A > TURN_CYC) ? MAX_A : TURN_CYC;
    localparam int CNT_W    = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
    localparam int LOW_W    = ADDR_W - 2;
    localparam int BANK_BIT = ADDR_W - 1;
    localparam int HI_BIT   = ADDR_W - 2;

    ctrl_state_t       state_q, state_d;
    logic              tmr_load, tmr_done;
    logic [CNT_W-1:0]  tmr_val;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, rdata_q;
    logic              ack_q, rd_recent_q;
    logic              accept, finish_rd, finish_wr, bank_active;
    logic [1:0]        sel_n, hi_line;

    assign accept    = (state_q == ST_IDLE) && req_valid && !ack_q;
    assign finish_rd = (state_q == ST_RD_ACC) && tmr_done;
    assign finish_wr = (state_q == ST_WR_PULSE) && tmr_done;

    // Next state and phase timer loads
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (!req_write) begin
                        state_d  = ST_RD_ACC;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(RD_CYC - 1);
                    end else if (rd_recent_q) begin
                        state_d  = ST_TURN;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(TURN_CYC - 1);
                    end else begin
                        state_d  = ST_WR_SETUP;
                    end
                end
            end
            ST_RD_ACC: begin
                if (tmr_done) state_d = ST_IDLE;
            end
            ST_TURN: begin
                if (tmr_done) state_d = ST_WR_SETUP;
            end
            ST_WR_SETUP: begin
                state_d  = ST_WR_PULSE;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(WP_CYC - 1);
            end
            ST_WR_PULSE: begin
                if (tmr_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Request capture, read capture and acknowledge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q      <= '0;
            wdata_q     <= '0;
            rdata_q     <= '0;
            ack_q       <= 1'b0;
            rd_recent_q <= 1'b0;
        end else begin
            ack_q <= finish_rd | finish_wr;
            if (accept) begin
                addr_q      <= req_addr;
                wdata_q     <= req_wdata;
                rd_recent_q <= 1'b0;
            end
            if (finish_rd) begin
                rdata_q     <= sram_dq_i;
                rd_recent_q <= 1'b1;
            end
        end
    end

    // Strobe decode from the state register
    always_comb begin
        bank_active   = 1'b0;
        sram_oe_n     = 1'b1;
        sram_we_n     = 1'b1;
        sram_dq_drive = 1'b0;
        unique case (state_q)
            ST_RD_ACC: begin
                bank_active = 1'b1;
                sram_oe_n   = 1'b0;
            end
            ST_WR_SETUP: bank_active = 1'b1;
            ST_WR_PULSE: begin
                bank_active   = 1'b1;
                sram_we_n     = 1'b0;
                sram_dq_drive = 1'b1;
            end
            default: ;
        endcase
    end

    dbsram_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    dbsram_bank_dec #(.SEL_W(1)) u_dec (
        .bank_sel (addr_q[BANK_BIT]),
        .hi_bit   (addr_q[HI_BIT]),
        .active   (bank_active),
        .sel_n    (sel_n),
        .hi_line  (hi_line)
    );

    assign sram_sel0_n = sel_n[0];
    assign sram_sel1_n = sel_n[1];
    assign sram_hi0    = hi_line[0];
    assign sram_hi1    = hi_line[1];
    assign sram_addr   = addr_q[LOW_W-1:0];
    assign sram_dq_o   = wdata_q;
    assign req_ack     = ack_q;
    assign rsp_rdata   = rdata_q;

    // Strobe run-length counters used by the checks below
    logic [CNT_W:0] oe_run_q, we_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_run_q <= '0;
            we_run_q <= '0;
        end else begin
            if (sram_oe_n)              oe_run_q <= '0;
            else if (oe_run_q != '1)    oe_run_q <= oe_run_q + 1'b1;
            if (sram_we_n)              we_run_q <= '0;
            else if (we_run_q != '1)    we_run_q <= we_run_q + 1'b1;
        end
    end

    assert_single_bank_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~{sram_sel1_n, sram_sel0_n}));

    assert_addr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!(sram_sel0_n & sram_sel1_n) && $past(!(sram_sel0_n & sram_sel1_n)))
        |-> ($stable(sram_addr) && $stable(sram_hi0) && $stable(sram_hi1)));

    assert_read_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_oe_n) |-> (oe_run_q >= (CNT_W+1)'(RD_CYC)));

    assert_write_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (we_run_q >= (CNT_W+1)'(WP_CYC)));

    assert_no_oe_in_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> sram_oe_n);

    assert_release_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> !sram_dq_drive);

    assert_ack_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !req_ack);

endmodule

// File: tb/dbsram_ctrl_test.sv
`timescale 1ns/1ps
module dbsram_ctrl_test;

    localparam int CLK_PERIOD = 5;
    localparam int EXP_RD   = (10 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int EXP_WP_A = (8 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int EXP_WP_B = (6 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int EXP_WP   = (EXP_WP_A > EXP_WP_B) ? EXP_WP_A : EXP_WP_B;
    localparam int EXP_TURN = (5 + CLK_PERIOD - 1) / CLK_PERIOD;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ack;
    logic [15:0] rsp_rdata;
    logic [14:0] sram_addr;
    logic        sram_hi0, sram_hi1, sram_sel0_n, sram_sel1_n, sram_we_n, sram_oe_n;
    logic [15:0] sram_dq_o;
    logic        sram_dq_drive;
    logic [15:0] sram_dq_i = 16'hEEEE;

    int checks = 0, failures = 0;

    always #(CLK_PERIOD/2.0) clk = ~clk;

    dbsram_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ack(req_ack),
        .rsp_rdata(rsp_rdata), .sram_addr(sram_addr), .sram_hi0(sram_hi0),
        .sram_hi1(sram_hi1), .sram_sel0_n(sram_sel0_n), .sram_sel1_n(sram_sel1_n),
        .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n), .sram_dq_o(sram_dq_o),
        .sram_dq_drive(sram_dq_drive), .sram_dq_i(sram_dq_i)
    );

    task automatic check(input bit ok, input string rq, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // Memory model of the two banks, keyed by {bank, line15, low address}
    logic [15:0] sram_mem [logic [16:0]];
    always @(negedge clk) begin
        logic [16:0] key;
        logic        any_sel;
        any_sel = !(sram_sel0_n && sram_sel1_n);
        key = !sram_sel0_n ? {1'b0, sram_hi0, sram_addr} : {1'b1, sram_hi1, sram_addr};
        if (any_sel && !sram_we_n)
            sram_mem[key] = sram_dq_drive ? sram_dq_o : 16'hBAD0;
        if (any_sel && !sram_oe_n && sram_we_n)
            sram_dq_i <= sram_mem.exists(key) ? sram_mem[key] : 16'hDEAD;
        else
            sram_dq_i <= 16'hEEEE;
    end

    // Scoreboard
    typedef struct { bit rd; logic [15:0] exp; logic [16:0] a; } sb_item_t;
    sb_item_t    sb_q[$];
    logic [15:0] ref_mem [logic [16:0]];
    bit          last_rd = 1'b0;

    always @(negedge clk) begin
        if (rst_n && req_ack) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R8", "acknowledge with nothing pending", 1, 0);
            end else begin
                sb_item_t it;
                it = sb_q.pop_front();
                if (it.rd)
                    check(rsp_rdata == it.exp, "R9", "read data", rsp_rdata, it.exp);
            end
        end
    end

    task automatic run_op(input bit wr, input logic [16:0] a, input logic [15:0] d,
                          input bit perturb);
        int lat = 0, ce_cnt = 0, oe_cnt = 0, we_cnt = 0, lead = 0;
        int bad_other = 0, bad_addr = 0, bad_dq = 0;
        bit seen = 1'b0;
        int exp_turn;
        sb_item_t it;
        exp_turn = (wr && last_rd) ? EXP_TURN : 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(posedge clk);
        it.rd = !wr; it.a = a;
        it.exp = ref_mem.exists(a) ? ref_mem[a] : 16'hDEAD;
        sb_q.push_back(it);
        if (wr) ref_mem[a] = d;
        for (int g = 0; g < 100; g++) begin
            logic mine_n, other_n, mine_hi, other_hi;
            @(negedge clk);
            lat++;
            req_valid = 1'b0;
            if (perturb) begin req_addr = ~a; req_wdata = ~d; end
            if (req_ack) break;
            mine_n   = a[16] ? sram_sel1_n : sram_sel0_n;
            other_n  = a[16] ? sram_sel0_n : sram_sel1_n;
            mine_hi  = a[16] ? sram_hi1 : sram_hi0;
            other_hi = a[16] ? sram_hi0 : sram_hi1;
            if (!mine_n) begin
                ce_cnt++; seen = 1'b1;
                if (sram_addr != a[14:0] || mine_hi != a[15] || other_hi != 1'b0) bad_addr++;
            end else if (!seen) lead++;
            if (!other_n) bad_other++;
            if (!sram_oe_n) oe_cnt++;
            if (!sram_we_n) we_cnt++;
            if (sram_dq_drive != !sram_we_n || (sram_dq_drive && !sram_oe_n)) bad_dq++;
        end
        check(bad_other == 0, "R2", "other bank selected cycles", bad_other, 0);
        check(bad_addr == 0, "R3", "address/line15 mismatches", bad_addr, 0);
        check(bad_dq == 0, "R6", "drive-enable misaligned cycles", bad_dq, 0);
        check(lead == exp_turn, "R7", "idle cycles before select", lead, exp_turn);
        if (wr) begin
            check(lat == EXP_WP + 2 + exp_turn, "R5", "write ack latency", lat, EXP_WP + 2 + exp_turn);
            check(we_cnt == EXP_WP, "R5", "write strobe low cycles", we_cnt, EXP_WP);
            check(oe_cnt == 0, "R5", "output enable low during write", oe_cnt, 0);
            check(ce_cnt == EXP_WP + 1, "R5", "select low cycles", ce_cnt, EXP_WP + 1);
        end else begin
            check(lat == EXP_RD + 1, "R4", "read ack latency", lat, EXP_RD + 1);
            check(oe_cnt == EXP_RD, "R4", "output enable low cycles", oe_cnt, EXP_RD);
            check(we_cnt == 0, "R4", "write strobe low during read", we_cnt, 0);
            check(ce_cnt == EXP_RD, "R4", "select low cycles", ce_cnt, EXP_RD);
        end
        @(negedge clk);
        check(req_ack == 1'b0, "R8", "acknowledge longer than one cycle", req_ack, 0);
        check(sram_sel0_n && sram_sel1_n && sram_we_n && sram_oe_n, "R8",
              "strobes idle after access", {sram_sel0_n, sram_sel1_n, sram_we_n, sram_oe_n}, 4'hF);
        last_rd = !wr;
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        check(1'b0, "R1", "watchdog expired", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(sram_sel0_n && sram_sel1_n && sram_we_n && sram_oe_n && !sram_dq_drive,
              "R1", "strobes during reset", {sram_sel0_n, sram_sel1_n, sram_we_n, sram_oe_n, sram_dq_drive}, 5'h1E);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(req_ack == 1'b0 && rsp_rdata == 16'h0, "R1", "ack/read data after reset", {req_ack, rsp_rdata}, 0);
        check(sram_sel0_n && sram_sel1_n && sram_we_n && sram_oe_n && !sram_dq_drive,
              "R1", "strobes after reset", {sram_sel0_n, sram_sel1_n, sram_we_n, sram_oe_n, sram_dq_drive}, 5'h1E);

        // Four addresses sharing low bits: bank and line-15 aliasing (R2, R3, R9)
        run_op(1'b1, 17'h00005, 16'hA1A1, 1'b0);
        run_op(1'b1, 17'h08005, 16'hB2B2, 1'b1);
        run_op(1'b1, 17'h10005, 16'hC3C3, 1'b0);
        run_op(1'b1, 17'h18005, 16'hD4D4, 1'b1);
        run_op(1'b0, 17'h00005, 16'h0, 1'b0);
        run_op(1'b0, 17'h08005, 16'h0, 1'b1);
        run_op(1'b0, 17'h10005, 16'h0, 1'b0);
        run_op(1'b0, 17'h18005, 16'h0, 1'b0);
        // Write right after read: turnaround gap (R7)
        run_op(1'b1, 17'h1FFFF, 16'hFFFF, 1'b1);
        run_op(1'b0, 17'h1FFFF, 16'h0, 1'b0);
        run_op(1'b1, 17'h00000, 16'h0000, 1'b0);
        run_op(1'b0, 17'h00000, 16'h0, 1'b0);
        // Overwrite and walking patterns across both banks
        run_op(1'b1, 17'h00005, 16'h5A5A, 1'b0);
        run_op(1'b0, 17'h00005, 16'h0, 1'b0);
        run_op(1'b0, 17'h08005, 16'h0, 1'b0);
        for (int i = 0; i < 16; i++) begin
            run_op(1'b1, 17'(i * 17'h1111), 16'(i * 16'h0F0F + 16'h3), i[0]);
        end
        for (int i = 0; i < 16; i++) begin
            run_op(1'b0, 17'(i * 17'h1111), 16'h0, i[1]);
        end
        repeat (4) @(negedge clk);
        check(sb_q.size() == 0, "R8", "pending scoreboard entries", sb_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule